// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block sits between a 32-bit register bus and a one-time-programmable fuse array of 128 words. Software reads the fuses through shadow registers, which are copied from the array by a reload command. Software writes a fuse word through a guarded sequence. First it writes the unlock key and the target word into the control register. Then it writes the program data. The controller reads the current fuse word, drops every bit that is already blown, and burns the remaining ones bit by bit. Each burn is a strobe pulse whose length, and the idle pad after it, come from the timing register.

Per-word lock inputs from the array control access. A program request to a program-locked word and a read of a read-locked shadow word are both refused and raise a sticky error flag. While that flag is set, the controller starts no new program or reload. After every program sequence, a guard interval of `GUARD_CYC` cycles keeps the controller busy before it accepts the next operation.

Bus reads are combinational: `bus_rdata` is valid in the same cycle as `bus_rd`. A bus write takes effect at the clock edge that samples it.

Top module: `fuse_ctl`

## Requirements
- R1: After reset the following hold:
  - The control word (offset 0x000) reads 0.
  - The timing word (offset 0x010) reads 0x00031009, that is, strobe length 9, pad 1 and read setting 3.
  - Every shadow word reads 0.
- R2: Programming is armed only when bits [31:16] of the control word hold 0x3E77.
  - The key can only be loaded by a direct write to offset 0x000.
  - A data write (offset 0x020) while idle always clears the key, so a second data write without re-arming starts nothing.
- R3: A program operation reads the target fuse word one cycle after the data write and forms the mask data & ~fuse.
  - It then walks bits 0 to 31 in ascending order. Each walk step takes one cycle.
  - For every mask bit that is 1, the walk step is followed by a strobe lasting (timing[11:0]+1) cycles and a pad lasting (timing[15:12]+1) cycles.
  - Only such bits are burned.
- R4: During programming the data register (offset 0x020) shifts right with zero fill, so it reads 0 when the operation ends.
  - Data writes while busy are ignored.
  - Data writes while idle load the register.
- R5: The target word is captured when programming starts. Later writes to the address field, bits [6:0], do not change the word being burned.
- R6: A program request to a program-locked word performs no fuse access and never sets busy (bit 8). It sets error (bit 9).
  - Error stays set until software writes 1 to bit 9 of the clear alias at offset 0x008.
  - The set alias (0x004) ORs bits [6:0] and starts a reload on bit 10.
- R7: Shadow word n is read at 0x400 + 0x10·n. A read of a read-locked word returns 0xBADABADA and sets error.
- R8: Writing 1 to bit 10 (via offset 0x000 or 0x004) while idle starts a reload.
  - Busy and bit 10 read 1 while the reload runs.
  - Word i is read from the array in cycle 2i+1 after the command and copied into shadow i.
  - Busy and bit 10 clear after the last word.
- R9: A shadow write during a reload is dropped and sets error.
- R10: While error is set, program requests and reload commands are refused, and the controller stays idle.
- R11: After the last bit of a program operation, busy stays high for `GUARD_CYC` further cycles.
  - No new operation can start in that window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when bus_rd is low |
| fuse_addr | output | 7 | Fuse word addressed by a read or a burn |
| fuse_rd | output | 1 | Fuse word read request; the array returns data in the next cycle |
| fuse_rdata | input | 32 | Fuse word returned by the array |
| fuse_strobe | output | 1 | Burn strobe for one fuse bit |
| fuse_bit | output | 5 | Bit index being burned |
| prog_lock | input | 128 | Per-word program lock from the array |
| read_lock | input | 128 | Per-word read lock from the array |

## Verification
Every result has a fixed due cycle, counted from the clock edge that samples the triggering bus write:
- The fuse read request appears in the first cycle after that edge.
- The first strobe of a set bit appears in the fourth cycle, and each later burn follows the fixed walk-strobe-pad pattern.
- An error flag raised by a refused request or a locked read is visible in the first cycle after the access.

For each program or reload command it accepts, the bench computes the complete per-cycle expected sequence of busy, reload bit, read requests, strobes, bit indices and addresses into a queue. It pops one entry on every falling edge and compares the entry against the live outputs.

Register checks read the bus mid-cycle, only after the queue has drained or at the point the requirement names. A refused or ignored request is therefore proven by an empty queue, with no strobe, read or busy, and by the unchanged fuse word.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

  localparam logic [15:0] UNLOCK_KEY  = 16'h3E77;
  localparam logic [31:0] LOCKED_WORD = 32'hBADA_BADA;

  localparam logic [11:0] A_CTRL   = 12'h000;
  localparam logic [11:0] A_SET    = 12'h004;
  localparam logic [11:0] A_CLR    = 12'h008;
  localparam logic [11:0] A_TIME   = 12'h010;
  localparam logic [11:0] A_DATA   = 12'h020;
  localparam logic [11:0] A_SHADOW = 12'h400;

  localparam int CB_ERR = 9;
  localparam int CB_RLD = 10;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRD,
    ST_PMASK,
    ST_PBIT,
    ST_PSTRB,
    ST_PRLX,
    ST_GUARD,
    ST_RRD,
    ST_RCAP
  } seq_st_t;

  typedef struct packed {
    logic [5:0]  rdset;
    logic [3:0]  relax;
    logic [11:0] prog;
  } timing_t;

endpackage

// File: rtl/fuse_seq.sv
module fuse_seq
  import fuse_pkg::*;
#(
  parameter int NWORDS    = 128,
  parameter int DW        = 32,
  parameter int GUARD_CYC = 20,
  localparam int AW = $clog2(NWORDS),
  localparam int BW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_ld,
  input  logic [DW-1:0] data_in,
  input  logic          prog_go,
  input  logic [AW-1:0] prog_addr_in,
  input  logic          reload_go,
  input  logic [11:0]   t_prog,
  input  logic [3:0]    t_relax,
  input  logic [DW-1:0] fuse_rdata,
  output logic          busy,
  output logic          reloading,
  output logic [DW-1:0] data_q,
  output logic [AW-1:0] fuse_addr,
  output logic          fuse_rd,
  output logic          fuse_strobe,
  output logic [BW-1:0] fuse_bit,
  output logic          sh_we,
  output logic [AW-1:0] sh_idx,
  output logic [DW-1:0] sh_wdata
);

  localparam int GW = $clog2(GUARD_CYC + 1);
  localparam int CW = (GW > 12) ? GW : 12;
  localparam logic [CW-1:0] GUARD_LD = CW'(GUARD_CYC - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);
  localparam logic [AW-1:0] LAST_WORD = AW'(NWORDS - 1);

  seq_st_t       st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [BW-1:0] bitn, bit_n;
  logic [DW-1:0] data_n;
  logic [AW-1:0] paddr, paddr_n;
  logic [AW-1:0] ridx, ridx_n;

  always_comb begin
    st_n    = st;
    cnt_n   = cnt;
    bit_n   = bitn;
    data_n  = data_q;
    paddr_n = paddr;
    ridx_n  = ridx;
    case (st)
      ST_IDLE: begin
        if (data_ld) data_n = data_in;
        if (prog_go) begin
          paddr_n = prog_addr_in;
          st_n    = ST_PRD;
        end else if (reload_go) begin
          ridx_n = '0;
          st_n   = ST_RRD;
        end
      end
      ST_PRD: st_n = ST_PMASK;
      ST_PMASK: begin
        data_n = data_q & ~fuse_rdata;
        bit_n  = '0;
        st_n   = ST_PBIT;
      end
      ST_PBIT: begin
        if (data_q[0]) begin
          cnt_n = CW'(t_prog);
          st_n  = ST_PSTRB;
        end else begin
          data_n = data_q >> 1;
          if (bitn == LAST_BIT) begin
            cnt_n = GUARD_LD;
            st_n  = ST_GUARD;
          end else begin
            bit_n = bitn + 1'b1;
          end
        end
      end
      ST_PSTRB: begin
        if (cnt == '0) begin
          cnt_n = CW'(t_relax);
          st_n  = ST_PRLX;
        end else begin
          cnt_n = cnt - 1'b1;
        end
      end
      ST_PRLX: begin
        if (cnt == '0) begin
          data_n = data_q >> 1;
          if (bitn == LAST_BIT) begin
            cnt_n = GUARD_LD;
            st_n  = ST_GUARD;
          end else begin
            bit_n = bitn + 1'b1;
            st_n  = ST_PBIT;
          end
        end else begin
          cnt_n = cnt - 1'b1;
        end
      end
      ST_GUARD: begin
        if (cnt == '0) st_n = ST_IDLE;
        else           cnt_n = cnt - 1'b1;
      end
      ST_RRD: st_n = ST_RCAP;
      ST_RCAP: begin
        if (ridx == LAST_WORD) st_n = ST_IDLE;
        else begin
          ridx_n = ridx + 1'b1;
          st_n   = ST_RRD;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      bitn   <= '0;
      data_q <= '0;
      paddr  <= '0;
      ridx   <= '0;
    end else begin
      st     <= st_n;
      cnt    <= cnt_n;
      bitn   <= bit_n;
      data_q <= data_n;
      paddr  <= paddr_n;
      ridx   <= ridx_n;
    end
  end

  assign busy        = (st != ST_IDLE);
  assign reloading   = (st == ST_RRD) || (st == ST_RCAP);
  assign fuse_rd     = (st == ST_PRD) || (st == ST_RRD);
  assign fuse_addr   = reloading ? ridx : paddr;
  assign fuse_strobe = (st == ST_PSTRB);
  assign fuse_bit    = bitn;
  assign sh_we       = (st == ST_RCAP);
  assign sh_idx      = ridx;
  assign sh_wdata    = fuse_rdata;

  logic in_prog;
  assign in_prog = st inside {ST_PRD, ST_PMASK, ST_PBIT, ST_PSTRB, ST_PRLX, ST_GUARD};

  // R5: captured target word holds for the whole program operation
  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_prog && $past(in_prog)) |-> $stable(paddr));

  // R3: a strobe never changes bit in the middle of its pulse
  p_strobe_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_strobe && $past(fuse_strobe)) |-> $stable(fuse_bit));

endmodule

// File: rtl/fuse_shadow.sv
module fuse_shadow #(
  parameter int NWORDS = 128,
  parameter int DW     = 32,
  localparam int AW = $clog2(NWORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ridx,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] words [NWORDS];

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    logic en;
    assign en = we && (widx == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  words[g] <= '0;
      else if (en) words[g] <= wdata;
    end
  end

  assign rdata = words[ridx];

endmodule

// File: rtl/fuse_ctl.sv
module fuse_ctl
  import fuse_pkg::*;
#(
  parameter int          NWORDS    = 128,
  parameter int          GUARD_CYC = 20,
  parameter logic [11:0] DEF_PROG  = 12'd9,
  parameter logic [3:0]  DEF_RELAX = 4'd1,
  parameter logic [5:0]  DEF_RDSET = 6'd3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [11:0]  bus_addr,
  input  logic [31:0]  bus_wdata,
  output logic [31:0]  bus_rdata,
  output logic [6:0]   fuse_addr,
  output logic         fuse_rd,
  input  logic [31:0]  fuse_rdata,
  output logic         fuse_strobe,
  output logic [4:0]   fuse_bit,
  input  logic [127:0] prog_lock,
  input  logic [127:0] read_lock
);

  localparam int AW = $clog2(NWORDS);
  localparam int DW = 32;
  localparam logic [7:0] NW_L = 8'(NWORDS);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  // decode
  logic [11:0]   sh_off;
  logic          in_sh;
  logic [AW-1:0] sh_n;
  logic wr_ctrl, wr_set, wr_clr, wr_time, wr_data, wr_sh, rd_sh;

  assign sh_off  = bus_addr - A_SHADOW;
  assign in_sh   = (bus_addr >= A_SHADOW) && (sh_off[3:0] == 4'h0) && (sh_off[11:4] < NW_L);
  assign sh_n    = sh_off[4 +: AW];
  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_set  = bus_wr && (bus_addr == A_SET);
  assign wr_clr  = bus_wr && (bus_addr == A_CLR);
  assign wr_time = bus_wr && (bus_addr == A_TIME);
  assign wr_data = bus_wr && (bus_addr == A_DATA);
  assign wr_sh   = bus_wr && in_sh;
  assign rd_sh   = bus_rd && in_sh;

  // registers
  logic [AW-1:0] addr_q, addr_d;
  logic [15:0]   key_q, key_d;
  logic          err_q, err_d, err_set;
  timing_t       tim_q, tim_d;
  logic          tim_en;

  logic          busy, reloading;
  logic [DW-1:0] data_q;
  logic          armed, data_ld, prog_go, reload_go;
  logic          seq_we;
  logic [AW-1:0] seq_idx;
  logic [DW-1:0] seq_wd;
  logic [AW-1:0] fuse_addr_w;

  assign armed     = (key_q == UNLOCK_KEY);
  assign data_ld   = wr_data && !busy;
  assign prog_go   = data_ld && armed && !err_q && !prog_lock[addr_q];
  assign reload_go = (wr_ctrl || wr_set) && bus_wdata[CB_RLD] && !busy && !err_q;
  assign err_set   = (data_ld && armed && !err_q && prog_lock[addr_q]) ||
                     (rd_sh && read_lock[sh_n]) ||
                     (wr_sh && reloading);

  always_comb begin
    addr_d = addr_q;
    if (wr_ctrl)     addr_d = bus_wdata[AW-1:0];
    else if (wr_set) addr_d = addr_q | bus_wdata[AW-1:0];
    else if (wr_clr) addr_d = addr_q & ~bus_wdata[AW-1:0];

    key_d = key_q;
    if (wr_ctrl)      key_d = bus_wdata[31:16];
    else if (data_ld) key_d = 16'h0000;

    err_d = err_q;
    if (wr_clr && bus_wdata[CB_ERR]) err_d = 1'b0;
    if (err_set)                     err_d = 1'b1;

    tim_en = wr_time;
    tim_d  = bus_wdata[21:0];
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      addr_q <= '0;
      key_q  <= '0;
      err_q  <= 1'b0;
      tim_q  <= '{rdset: DEF_RDSET, relax: DEF_RELAX, prog: DEF_PROG};
    end else begin
      addr_q <= addr_d;
      key_q  <= key_d;
      err_q  <= err_d;
      if (tim_en) tim_q <= tim_d;
    end
  end

  fuse_seq #(.NWORDS(NWORDS), .DW(DW), .GUARD_CYC(GUARD_CYC)) u_seq (
    .clk          (clk),
    .rst_n        (rst_sn),
    .data_ld      (data_ld),
    .data_in      (bus_wdata),
    .prog_go      (prog_go),
    .prog_addr_in (addr_q),
    .reload_go    (reload_go),
    .t_prog       (tim_q.prog),
    .t_relax      (tim_q.relax),
    .fuse_rdata   (fuse_rdata),
    .busy         (busy),
    .reloading    (reloading),
    .data_q       (data_q),
    .fuse_addr    (fuse_addr_w),
    .fuse_rd      (fuse_rd),
    .fuse_strobe  (fuse_strobe),
    .fuse_bit     (fuse_bit),
    .sh_we        (seq_we),
    .sh_idx       (seq_idx),
    .sh_wdata     (seq_wd)
  );

  assign fuse_addr = 7'(fuse_addr_w);

  logic          shw_en;
  logic [AW-1:0] shw_idx;
  logic [DW-1:0] shw_data, sh_rdata;

  assign shw_en   = seq_we || (wr_sh && !reloading);
  assign shw_idx  = seq_we ? seq_idx : sh_n;
  assign shw_data = seq_we ? seq_wd : bus_wdata;

  fuse_shadow #(.NWORDS(NWORDS), .DW(DW)) u_shadow (
    .clk   (clk),
    .rst_n (rst_sn),
    .we    (shw_en),
    .widx  (shw_idx),
    .wdata (shw_data),
    .ridx  (sh_n),
    .rdata (sh_rdata)
  );

  logic [31:0] ctrl_word;
  assign ctrl_word = {key_q, 5'b0, reloading, err_q, busy, 1'b0, 7'(addr_q)};

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_CTRL, A_SET, A_CLR: bus_rdata = ctrl_word;
        A_TIME:               bus_rdata = {10'b0, tim_q};
        A_DATA:               bus_rdata = data_q;
        default: if (in_sh)   bus_rdata = read_lock[sh_n] ? LOCKED_WORD : sh_rdata;
      endcase
    end
  end

  // R6: error is sticky until cleared through the clear alias
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (err_q && !(wr_clr && bus_wdata[CB_ERR])) |=> err_q);

  // R6: program request to a locked word never raises busy
  p_lock_nobusy_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_data && !busy && armed && prog_lock[addr_q]) |=> !busy);

  // R7: read of a read-locked shadow word flags error
  p_rdlock_err_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_sh && read_lock[sh_n]) |=> err_q);

  // R9: shadow write during reload flags error
  p_reload_shwr_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_sh && reloading) |=> err_q);

  // R10: with error set a data write leaves the controller idle
  p_err_refuse_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    (err_q && wr_data && !busy) |=> !busy);

endmodule

// File: tb/sim_fuse_ctl.sv
module sim_fuse_ctl;
  import fuse_pkg::*;

  localparam int CLK_P = 10;
  localparam int NW    = 128;
  localparam int G     = 20;
  localparam int SP    = 2;
  localparam int RL    = 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         bus_wr, bus_rd;
  logic [11:0]  bus_addr;
  logic [31:0]  bus_wdata, bus_rdata;
  logic [6:0]   fuse_addr;
  logic         fuse_rd, fuse_strobe;
  logic [31:0]  fuse_rdata;
  logic [4:0]   fuse_bit;
  logic [127:0] prog_lock, read_lock;

  always #(CLK_P/2) clk = ~clk;

  fuse_ctl #(.NWORDS(NW), .GUARD_CYC(G)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fuse_addr(fuse_addr), .fuse_rd(fuse_rd), .fuse_rdata(fuse_rdata),
    .fuse_strobe(fuse_strobe), .fuse_bit(fuse_bit),
    .prog_lock(prog_lock), .read_lock(read_lock)
  );

  // behavioural fuse array
  logic [31:0] fmem [NW];
  logic [31:0] frd;
  assign fuse_rdata = frd;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) fmem[i] <= {8'(i * 3), 8'(i), 8'h00, 8'h30};
      frd <= '0;
    end else begin
      if (fuse_rd) frd <= fmem[fuse_addr];
      if (fuse_strobe) fmem[fuse_addr][fuse_bit] <= 1'b1;
    end
  end

  typedef struct packed {
    logic       busy;
    logic       rl;
    logic       strb;
    logic [4:0] bn;
    logic       rd;
    logic [6:0] a;
  } ev_t;

  ev_t q[$];
  int  ncmp = 0;
  int  nerr = 0;
  bit  started = 0;
  bit  done = 0;

  // per-cycle reference comparison
  always @(negedge clk) begin
    ev_t e;
    bit  ok;
    if (started && !done) begin
      e = '0;
      if (q.size() > 0) e = q.pop_front();
      ok = 1;
      if (fuse_strobe !== e.strb || fuse_rd !== e.rd) ok = 0;
      if ((e.strb || e.rd) && fuse_addr !== e.a) ok = 0;
      if (e.strb && fuse_bit !== e.bn) ok = 0;
      if (bus_rd && bus_addr == A_CTRL &&
          (bus_rdata[8] !== e.busy || bus_rdata[10] !== e.rl)) ok = 0;
      ncmp++;
      if (!ok) begin
        nerr++;
        $display("FAIL R3/R5/R8/R11 timeline t=%0t act strb=%b rd=%b a=%0d bit=%0d ctrl=%h exp strb=%b rd=%b a=%0d bit=%0d busy=%b rl=%b",
                 $time, fuse_strobe, fuse_rd, fuse_addr, fuse_bit, bus_rdata,
                 e.strb, e.rd, e.a, e.bn, e.busy, e.rl);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ncmp++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = A_CTRL; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    @(posedge clk); #1;
    bus_addr = A_CTRL;
  endtask

  task automatic push_prog(input logic [6:0] a, input logic [31:0] d, input logic [31:0] old);
    logic [31:0] m;
    m = d & ~old;
    q.push_back('{busy:1'b1, rl:1'b0, strb:1'b0, bn:5'd0, rd:1'b1, a:a});
    q.push_back('{busy:1'b1, rl:1'b0, strb:1'b0, bn:5'd0, rd:1'b0, a:7'd0});
    for (int b = 0; b < 32; b++) begin
      q.push_back('{busy:1'b1, rl:1'b0, strb:1'b0, bn:5'd0, rd:1'b0, a:7'd0});
      if (m[b]) begin
        for (int k = 0; k <= SP; k++)
          q.push_back('{busy:1'b1, rl:1'b0, strb:1'b1, bn:5'(b), rd:1'b0, a:a});
        for (int k = 0; k <= RL; k++)
          q.push_back('{busy:1'b1, rl:1'b0, strb:1'b0, bn:5'd0, rd:1'b0, a:7'd0});
      end
    end
    for (int k = 0; k < G; k++)
      q.push_back('{busy:1'b1, rl:1'b0, strb:1'b0, bn:5'd0, rd:1'b0, a:7'd0});
  endtask

  task automatic push_reload();
    for (int i = 0; i < NW; i++) begin
      q.push_back('{busy:1'b1, rl:1'b1, strb:1'b0, bn:5'd0, rd:1'b1, a:7'(i)});
      q.push_back('{busy:1'b1, rl:1'b1, strb:1'b0, bn:5'd0, rd:1'b0, a:7'd0});
    end
  endtask

  task automatic wait_idle();
    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  function automatic logic [11:0] shaddr(input int n);
    return A_SHADOW + 12'(n * 16);
  endfunction

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d, old5, old9, old12, old3, old0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = A_CTRL; bus_wdata = '0;
    prog_lock = '0; read_lock = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 started = 1;

    // R1 reset state
    bus_read(A_CTRL, d);       chk("R1 ctrl after reset", d, 32'h0);
    bus_read(A_TIME, d);       chk("R1 timing default", d, 32'h0003_1009);
    bus_read(shaddr(5), d);    chk("R1 shadow after reset", d, 32'h0);

    // R3 timing field layout
    bus_write(A_TIME, 32'hFFFF_FFFF);
    bus_read(A_TIME, d);       chk("R3 timing field mask", d, 32'h003F_FFFF);
    bus_write(A_TIME, 32'h0000_1002);
    bus_read(A_TIME, d);       chk("R3 timing readback", d, 32'h0000_1002);

    // R2 arming and first program, with R4/R5 disturbance while busy
    old5 = fmem[5];
    bus_write(A_CTRL, {UNLOCK_KEY, 16'h0005});
    bus_read(A_CTRL, d);       chk("R2 key field loaded", d, 32'h3E77_0005);
    bus_write(A_DATA, 32'h0000_00A5);
    push_prog(7'd5, 32'h0000_00A5, old5);
    repeat (3) @(posedge clk);
    bus_write(A_CTRL, 32'h0000_0009);   // R5 address change mid-program
    bus_write(A_DATA, 32'hFFFF_FFFF);   // R4 ignored while busy
    wait_idle();
    chk("R3 burned word 5", fmem[5], old5 | 32'h0000_00A5);
    bus_read(A_DATA, d);       chk("R4 data shifted out", d, 32'h0);
    bus_read(A_CTRL, d);       chk("R2 key cleared after start", d, 32'h0000_0009);

    // R3 second pattern incl. bit 31, R11 guard refuses new request
    old9 = fmem[9];
    bus_write(A_CTRL, {UNLOCK_KEY, 16'h0009});
    bus_write(A_DATA, 32'hF000_0001);
    push_prog(7'd9, 32'hF000_0001, old9);
    while (q.size() > 10) @(posedge clk);
    bus_write(A_CTRL, {UNLOCK_KEY, 16'h0009});
    bus_write(A_DATA, 32'h1234_5678);   // R11 during guard: ignored
    wait_idle();
    chk("R11 no program from guard window", fmem[9], old9 | 32'hF000_0001);

    // R2 no start without re-arming
    bus_write(A_CTRL, 32'h0);
    old0 = fmem[0];
    bus_write(A_DATA, 32'h0000_FF00);
    repeat (5) @(posedge clk);
    chk("R2 unarmed write burns nothing", fmem[0], old0);
    bus_read(A_DATA, d);       chk("R4 idle write loads data", d, 32'h0000_FF00);

    // R6 locked word
    prog_lock[12] = 1'b1;
    old12 = fmem[12];
    bus_write(A_CTRL, {UNLOCK_KEY, 16'h000C});
    bus_write(A_DATA, 32'h0000_FFFF);
    bus_read(A_CTRL, d);       chk("R6 locked sets error no busy", d, 32'h0000_020C);
    chk("R6 locked word untouched", fmem[12], old12);

    // R10 refusal while error set
    old3 = fmem[3];
    bus_write(A_CTRL, {UNLOCK_KEY, 16'h0003});
    bus_write(A_DATA, 32'h0000_0001);
    bus_write(A_SET, 32'h0000_0400);
    repeat (3) @(posedge clk);
    bus_read(A_CTRL, d);       chk("R10 refused, R6 error sticky", d, 32'h0000_0203);
    chk("R10 word 3 untouched", fmem[3], old3);
    bus_write(A_CLR, 32'h0000_0200);
    bus_read(A_CTRL, d);       chk("R6 error cleared by alias", d, 32'h0000_0003);

    // R8 reload with R9 shadow write during it
    bus_write(A_SET, 32'h0000_0400);
    push_reload();
    while (q.size() > 150) @(posedge clk);
    bus_write(shaddr(2), 32'hDEAD_BEEF);
    wait_idle();
    bus_read(A_CTRL, d);       chk("R9 error after shadow write in reload", d, 32'h0000_0203);
    bus_read(shaddr(2), d);    chk("R9 shadow write dropped", d, fmem[2]);
    bus_read(shaddr(5), d);    chk("R8 shadow 5", d, fmem[5]);
    bus_read(shaddr(9), d);    chk("R8 shadow 9", d, fmem[9]);
    bus_read(shaddr(0), d);    chk("R8 shadow 0", d, fmem[0]);
    bus_read(shaddr(127), d);  chk("R8 shadow 127", d, fmem[127]);
    bus_write(A_CLR, 32'h0000_0200);

    // R7 read-locked shadow
    read_lock[9] = 1'b1;
    bus_read(shaddr(9), d);    chk("R7 locked read pattern", d, LOCKED_WORD);
    bus_read(A_CTRL, d);       chk("R7 locked read sets error", d, 32'h0000_0203);
    bus_write(A_CLR, 32'h0000_0200);
    read_lock[9] = 1'b0;
    bus_read(shaddr(9), d);    chk("R7 unlocked read", d, fmem[9]);
    bus_read(A_CTRL, d);       chk("R7 no error on plain read", d, 32'h0000_0003);

    wait_idle();
    finish_run();
  end

endmodule